// File: doc/BRIEF.md
# Bus Cycle Exception Decoder

This block sits in the cycle-termination path of a bus master. Once a bus cycle has been started it watches three active-low inputs on every clock edge: the normal acknowledge, the bus error line and the halt line. It then decides how the cycle ends. The possible outcomes are normal completion, a bus error exception, a retry of the same cycle, or a suspension of bus activity. Each outcome is reported for one clock as a two-bit code. After a retry, the block holds the cycle's address and direction. It reissues the cycle once both exception lines have been released.

The halt pin is shared and open-drain. When the processor reports a double bus fault, the block pulls that pin low and keeps it low until reset. While a fault is latched, no further outcome is produced. The block also drives a lock output that spans every cycle of an indivisible read-modify-write sequence. It offers a grant-permission signal that is withheld while the lock is active, so the bus owner cannot change in the middle of the sequence.

States: IDLE (no cycle; a start is accepted here), ACTIVE (cycle in flight, waiting for termination), SUSPEND (halt seen alone; cycle held), RETRY_WAIT (retry decided; waiting for both lines to release), FAULT (double fault latched). Transitions: IDLE->ACTIVE on accepted start; ACTIVE->IDLE on normal or error; ACTIVE->RETRY_WAIT on retry; ACTIVE->SUSPEND on halt alone; SUSPEND->ACTIVE on halt release; SUSPEND->RETRY_WAIT on bus error during suspension; RETRY_WAIT->ACTIVE on reissue; any state->FAULT on double fault.

Top module: `bce_top`

## Requirements
- R1: In ACTIVE, bus error low with halt high gives one-cycle `done_o` with `outcome_o` = 01 on the next clock, and the block returns to idle (`busy_o` low).
- R2: In ACTIVE, bus error and halt both low in the same sample give `outcome_o` = 10 on the next clock, and the cycle stays pending (`busy_o` high).
- R3: In ACTIVE, acknowledge low with bus error high gives `outcome_o` = 00 on the next clock and a return to idle.
- R4: In ACTIVE, halt low alone gives `outcome_o` = 11 and holds the cycle (acknowledge ignored). Halt release resumes waiting for termination. Bus error while suspended gives `outcome_o` = 10.
- R5: A start request is ignored while halt is low in idle, and while a cycle is already pending; `cur_addr_o` keeps its value.
- R6: After a retry, `reissue_o` pulses for one clock only once both halt and bus error are high. `cur_addr_o`/`cur_write_o` equal the retried cycle's values and the cycle is pending again.
- R7: A `dbl_fault_i` pulse sets `halt_oe_o` (pin pulled low) on the next clock; it stays set until reset, and no `done_o`, `reissue_o` or start acceptance happens meanwhile.
- R8: `lock_o` rises the clock after a start accepted with `rmw_i` high, stays high while `rmw_i` stays high across cycles, and clears the clock after the block is idle with `rmw_i` low.
- R9: `grant_ok_o` is high only when idle and not locked.
- R10: After reset: `busy_o`, `done_o`, `reissue_o`, `lock_o`, `halt_oe_o` low and `grant_ok_o` high.
- R11: `done_o` is a single-clock strobe; bus error takes priority over acknowledge (both low give 01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Request to begin a bus cycle |
| addr_i | input | ADDR_W | Address of the requested cycle |
| write_i | input | 1 | Direction of the requested cycle (1 = write) |
| rmw_i | input | 1 | High across an indivisible read-modify-write sequence |
| ack_n_i | input | 1 | Active-low normal termination |
| berr_n_i | input | 1 | Active-low bus error |
| halt_n_i | input | 1 | Active-low halt pin level as read |
| dbl_fault_i | input | 1 | Double bus fault report from the processor |
| halt_oe_o | output | 1 | Pull halt pin low (open-drain enable) |
| lock_o | output | 1 | Read-modify-write lock indication |
| grant_ok_o | output | 1 | Bus ownership may be handed over |
| busy_o | output | 1 | A cycle is pending or the block is faulted |
| done_o | output | 1 | One-clock outcome strobe |
| outcome_o | output | 2 | Outcome code: 00 normal, 01 error, 10 retry, 11 halt |
| reissue_o | output | 1 | One-clock strobe: retried cycle reissued |
| cur_addr_o | output | ADDR_W | Address of the pending cycle |
| cur_write_o | output | 1 | Direction of the pending cycle |

## Verification
The bench drives bus error together with halt and with acknowledge. A decoder with the wrong priority would report an error or a normal end where a retry or an error belongs. It releases the two lines of a retry one at a time. A design that reissued too early would pulse `reissue_o` while halt is still low. It also applies acknowledge during a suspension, where a careless design would end the cycle. Finally it checks that starts are dropped while halt is low, that the lock survives the idle gap between read and write, and that a double fault silences all strobes until reset.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef enum logic [1:0] {
        OUT_NORMAL = 2'b00,
        OUT_ERROR  = 2'b01,
        OUT_RETRY  = 2'b10,
        OUT_HALT   = 2'b11
    } outcome_t;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_ACTIVE     = 3'd1,
        ST_SUSPEND    = 3'd2,
        ST_RETRY_WAIT = 3'd3,
        ST_FAULT      = 3'd4
    } state_t;

    typedef enum logic [2:0] {
        TERM_NONE   = 3'd0,
        TERM_NORMAL = 3'd1,
        TERM_ERROR  = 3'd2,
        TERM_RETRY  = 3'd3,
        TERM_HALT   = 3'd4
    } term_t;

endpackage

// File: rtl/bce_term_decode.sv
// Joint decode of the three termination lines sampled on one edge.
module bce_term_decode
    import bce_pkg::*;
(
    input  logic  ack_n_i,
    input  logic  berr_n_i,
    input  logic  halt_n_i,
    output term_t term_o
);
    always_comb begin
        if (!berr_n_i && !halt_n_i) begin
            term_o = TERM_RETRY;
        end else if (!berr_n_i) begin
            term_o = TERM_ERROR;
        end else if (!ack_n_i) begin
            term_o = TERM_NORMAL;
        end else if (!halt_n_i) begin
            term_o = TERM_HALT;
        end else begin
            term_o = TERM_NONE;
        end
    end
endmodule

// File: rtl/bce_cycle_fsm.sv
// Cycle outcome state machine with registered strobes and held cycle attributes.
module bce_cycle_fsm
    import bce_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  term_t             term_i,
    input  logic              halt_n_i,
    input  logic              berr_n_i,
    input  logic              fault_i,
    output state_t            state_o,
    output logic              done_o,
    output outcome_t          outcome_o,
    output logic              reissue_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              cur_write_o
);
    state_t            st_q, st_nx;
    logic              done_nx, reissue_nx, capture;
    outcome_t          code_nx;
    logic              done_q, reissue_q, write_q;
    outcome_t          code_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        st_nx      = st_q;
        done_nx    = 1'b0;
        reissue_nx = 1'b0;
        code_nx    = OUT_NORMAL;
        capture    = 1'b0;
        if (fault_i) begin
            st_nx = ST_FAULT;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i && halt_n_i) begin
                        capture = 1'b1;
                        st_nx   = ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    unique case (term_i)
                        TERM_NORMAL: begin
                            done_nx = 1'b1;
                            code_nx = OUT_NORMAL;
                            st_nx   = ST_IDLE;
                        end
                        TERM_ERROR: begin
                            done_nx = 1'b1;
                            code_nx = OUT_ERROR;
                            st_nx   = ST_IDLE;
                        end
                        TERM_RETRY: begin
                            done_nx = 1'b1;
                            code_nx = OUT_RETRY;
                            st_nx   = ST_RETRY_WAIT;
                        end
                        TERM_HALT: begin
                            done_nx = 1'b1;
                            code_nx = OUT_HALT;
                            st_nx   = ST_SUSPEND;
                        end
                        default: st_nx = ST_ACTIVE;
                    endcase
                end
                ST_SUSPEND: begin
                    if (!berr_n_i && !halt_n_i) begin
                        done_nx = 1'b1;
                        code_nx = OUT_RETRY;
                        st_nx   = ST_RETRY_WAIT;
                    end else if (halt_n_i) begin
                        st_nx = ST_ACTIVE;
                    end
                end
                ST_RETRY_WAIT: begin
                    if (halt_n_i && berr_n_i) begin
                        reissue_nx = 1'b1;
                        st_nx      = ST_ACTIVE;
                    end
                end
                ST_FAULT: st_nx = ST_FAULT;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            code_q    <= OUT_NORMAL;
            reissue_q <= 1'b0;
            addr_q    <= '0;
            write_q   <= 1'b0;
        end else begin
            done_q    <= done_nx;
            code_q    <= code_nx;
            reissue_q <= reissue_nx;
            if (capture) begin
                addr_q  <= addr_i;
                write_q <= write_i;
            end
        end
    end

    assign state_o     = st_q;
    assign done_o      = done_q;
    assign outcome_o   = code_q;
    assign reissue_o   = reissue_q;
    assign cur_addr_o  = addr_q;
    assign cur_write_o = write_q;
endmodule

// File: rtl/bce_lock_track.sv
// Read-modify-write lock and grant permission.
module bce_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic rmw_i,
    input  logic idle_i,
    output logic lock_o,
    output logic grant_ok_o
);
    logic lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (accept_i && rmw_i) begin
            lock_q <= 1'b1;
        end else if (idle_i && !rmw_i) begin
            lock_q <= 1'b0;
        end
    end

    assign lock_o     = lock_q;
    assign grant_ok_o = idle_i && !lock_q;
endmodule

// File: rtl/bce_halt_drive.sv
// Latches a double-fault report and pulls the shared halt pin low.
module bce_halt_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_fault_i,
    output logic halt_oe_o
);
    logic fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (dbl_fault_i) begin
            fault_q <= 1'b1;
        end
    end

    assign halt_oe_o = fault_q;
endmodule

// File: rtl/bce_top.sv
module bce_top
    import bce_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic              rmw_i,
    input  logic              ack_n_i,
    input  logic              berr_n_i,
    input  logic              halt_n_i,
    input  logic              dbl_fault_i,
    output logic              halt_oe_o,
    output logic              lock_o,
    output logic              grant_ok_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        outcome_o,
    output logic              reissue_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              cur_write_o
);
    term_t    term;
    state_t   st;
    outcome_t code;
    logic     idle, accept;

    bce_term_decode u_decode (
        .ack_n_i  (ack_n_i),
        .berr_n_i (berr_n_i),
        .halt_n_i (halt_n_i),
        .term_o   (term)
    );

    bce_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .write_i     (write_i),
        .term_i      (term),
        .halt_n_i    (halt_n_i),
        .berr_n_i    (berr_n_i),
        .fault_i     (dbl_fault_i),
        .state_o     (st),
        .done_o      (done_o),
        .outcome_o   (code),
        .reissue_o   (reissue_o),
        .cur_addr_o  (cur_addr_o),
        .cur_write_o (cur_write_o)
    );

    assign idle      = (st == ST_IDLE);
    assign accept    = idle && start_i && halt_n_i && !dbl_fault_i;
    assign busy_o    = !idle;
    assign outcome_o = code;

    bce_lock_track u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .rmw_i      (rmw_i),
        .idle_i     (idle),
        .lock_o     (lock_o),
        .grant_ok_o (grant_ok_o)
    );

    bce_halt_drive u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbl_fault_i (dbl_fault_i),
        .halt_oe_o   (halt_oe_o)
    );
endmodule

// File: rtl/bce_checker.sv
module bce_checker
    import bce_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input state_t            st,
    input logic              start_i,
    input logic              rmw_i,
    input logic              ack_n_i,
    input logic              berr_n_i,
    input logic              halt_n_i,
    input logic              dbl_fault_i,
    input logic              halt_oe_o,
    input logic              lock_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        outcome_o,
    input logic              reissue_o,
    input logic [ADDR_W-1:0] cur_addr_o
);
    a_r1_error_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && !berr_n_i && halt_n_i && !dbl_fault_i)
        |=> (done_o && outcome_o == 2'b01 && !busy_o));

    a_r2_retry_joint: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && !berr_n_i && !halt_n_i && !dbl_fault_i)
        |=> (done_o && outcome_o == 2'b10 && busy_o));

    a_r3_normal_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && berr_n_i && !ack_n_i && !dbl_fault_i)
        |=> (done_o && outcome_o == 2'b00));

    a_r5_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !halt_n_i && !dbl_fault_i) |=> !busy_o);

    a_r6_reissue_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_o |-> (busy_o && cur_addr_o == $past(cur_addr_o)));

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt_oe_o |=> halt_oe_o);

    a_r7_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halt_oe_o |-> (!done_o && !reissue_o));

    a_r8_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && halt_n_i && rmw_i && !dbl_fault_i) |=> lock_o);

    a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && rmw_i) |=> lock_o);
endmodule

bind bce_top bce_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .start_i     (start_i),
    .rmw_i       (rmw_i),
    .ack_n_i     (ack_n_i),
    .berr_n_i    (berr_n_i),
    .halt_n_i    (halt_n_i),
    .dbl_fault_i (dbl_fault_i),
    .halt_oe_o   (halt_oe_o),
    .lock_o      (lock_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .outcome_o   (outcome_o),
    .reissue_o   (reissue_o),
    .cur_addr_o  (cur_addr_o)
);

// File: tb/bce_top_tb_top.sv
`timescale 1ns/1ps
module bce_top_tb_top;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          write_i = 1'b0;
    logic          rmw_i = 1'b0;
    logic          ack_n_i = 1'b1;
    logic          berr_n_i = 1'b1;
    logic          halt_ext_n = 1'b1;
    logic          dbl_fault_i = 1'b0;
    logic          halt_n_pin;
    logic          halt_oe_o, lock_o, grant_ok_o, busy_o, done_o, reissue_o, cur_write_o;
    logic [1:0]    outcome_o;
    logic [AW-1:0] cur_addr_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // wired open-drain halt pin
    assign halt_n_pin = halt_ext_n & ~halt_oe_o;

    bce_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .write_i(write_i), .rmw_i(rmw_i), .ack_n_i(ack_n_i), .berr_n_i(berr_n_i),
        .halt_n_i(halt_n_pin), .dbl_fault_i(dbl_fault_i), .halt_oe_o(halt_oe_o),
        .lock_o(lock_o), .grant_ok_o(grant_ok_o), .busy_o(busy_o), .done_o(done_o),
        .outcome_o(outcome_o), .reissue_o(reissue_o), .cur_addr_o(cur_addr_o),
        .cur_write_o(cur_write_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 0; rmw_i = 0; ack_n_i = 1; berr_n_i = 1; halt_ext_n = 1; dbl_fault_i = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic begin_cycle(input logic [AW-1:0] a, input logic w);
        start_i = 1; addr_i = a; write_i = w;
        step();
        start_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 busy", busy_o, 0);
        check("R10 done", done_o, 0);
        check("R10 reissue", reissue_o, 0);
        check("R10 lock", lock_o, 0);
        check("R10 halt_oe", halt_oe_o, 0);
        check("R10 grant_ok", grant_ok_o, 1);
    endtask

    task automatic t_normal();
        begin_cycle(24'h12_3456, 1'b1);
        check("R3 busy", busy_o, 1);
        check("R3 addr", cur_addr_o, 24'h12_3456);
        check("R9 grant while busy", grant_ok_o, 0);
        ack_n_i = 0; step(); ack_n_i = 1;
        check("R3 done", done_o, 1);
        check("R3 code", outcome_o, 2'b00);
        check("R3 idle", busy_o, 0);
        step();
        check("R11 strobe width", done_o, 0);
    endtask

    task automatic t_error();
        begin_cycle(24'h00_0100, 1'b0);
        berr_n_i = 0; step(); berr_n_i = 1;
        check("R1 done", done_o, 1);
        check("R1 code", outcome_o, 2'b01);
        check("R1 idle", busy_o, 0);
        begin_cycle(24'h00_0200, 1'b0);
        berr_n_i = 0; ack_n_i = 0; step(); berr_n_i = 1; ack_n_i = 1;
        check("R11 berr over ack", outcome_o, 2'b01);
    endtask

    task automatic t_retry();
        begin_cycle(24'hAB_CDEF, 1'b1);
        berr_n_i = 0; halt_ext_n = 0; step();
        check("R2 done", done_o, 1);
        check("R2 code", outcome_o, 2'b10);
        check("R2 pending", busy_o, 1);
        berr_n_i = 1; step();
        check("R6 no early reissue", reissue_o, 0);
        halt_ext_n = 1; addr_i = 24'h11_1111; step();
        check("R6 reissue", reissue_o, 1);
        check("R6 same addr", cur_addr_o, 24'hAB_CDEF);
        check("R6 same dir", cur_write_o, 1);
        step();
        check("R6 reissue pulse", reissue_o, 0);
        ack_n_i = 0; step(); ack_n_i = 1;
        check("R6 reissued completes", outcome_o, 2'b00);
    endtask

    task automatic t_halt();
        begin_cycle(24'h00_0300, 1'b0);
        halt_ext_n = 0; step();
        check("R4 done", done_o, 1);
        check("R4 code", outcome_o, 2'b11);
        ack_n_i = 0; step(); ack_n_i = 1;
        check("R4 ack ignored", done_o, 0);
        check("R4 held", busy_o, 1);
        halt_ext_n = 1; step();
        check("R4 resumed", busy_o, 1);
        ack_n_i = 0; step(); ack_n_i = 1;
        check("R4 end after release", outcome_o, 2'b00);
        begin_cycle(24'h00_0400, 1'b0);
        halt_ext_n = 0; step();
        berr_n_i = 0; step();
        check("R4 berr in suspend", outcome_o, 2'b10);
        check("R4 berr strobe", done_o, 1);
        berr_n_i = 1; halt_ext_n = 1; step();
        check("R6 reissue after suspend", reissue_o, 1);
        ack_n_i = 0; step(); ack_n_i = 1;
        step();
    endtask

    task automatic t_ignore();
        halt_ext_n = 0;
        begin_cycle(24'h55_5555, 1'b1);
        check("R5 start under halt", busy_o, 0);
        check("R5 addr kept", cur_addr_o, 24'h00_0400);
        halt_ext_n = 1;
        begin_cycle(24'h66_6666, 1'b0);
        begin_cycle(24'h77_7777, 1'b1);
        check("R5 start while busy", cur_addr_o, 24'h66_6666);
        ack_n_i = 0; step(); ack_n_i = 1;
    endtask

    task automatic t_lock();
        rmw_i = 1;
        begin_cycle(24'h00_0800, 1'b0);
        check("R8 lock set", lock_o, 1);
        ack_n_i = 0; step(); ack_n_i = 1;
        check("R8 lock across gap", lock_o, 1);
        check("R9 no grant locked", grant_ok_o, 0);
        begin_cycle(24'h00_0800, 1'b1);
        ack_n_i = 0; step(); ack_n_i = 1;
        rmw_i = 0; step();
        check("R8 lock cleared", lock_o, 0);
        check("R9 grant free", grant_ok_o, 1);
    endtask

    task automatic t_fault();
        begin_cycle(24'h00_0900, 1'b0);
        dbl_fault_i = 1; step(); dbl_fault_i = 0;
        check("R7 halt driven", halt_oe_o, 1);
        check("R7 pin low", halt_n_pin, 0);
        berr_n_i = 0; step(); berr_n_i = 1;
        check("R7 no outcome", done_o, 0);
        begin_cycle(24'h00_0A00, 1'b0);
        check("R7 start ignored", cur_addr_o, 24'h00_0900);
        step(); step();
        check("R7 still driven", halt_oe_o, 1);
        check("R9 no grant faulted", grant_ok_o, 0);
        do_reset();
        check("R7 reset clears", halt_oe_o, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_error();
        t_retry();
        t_halt();
        t_ignore();
        t_lock();
        t_fault();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule